// File: doc/BRIEF.md
# Single-Scan Command Queue Trigger Controller

This block decides when one command queue of a queued analog-to-digital converter may hand commands to the shared arbiter while the queue runs in single-scan operation. Software writes an operating mode and may, in the same write, fire a write-one scan-enable strobe. The strobe sets a scan-status bit that only the hardware can clear. Each trigger source is ignored unless scan-status is set. The sources are the software trigger, a rising or falling edge on the external trigger pin, and a high or low level gate on that pin.

Once triggered, the block raises a transfer request toward the arbiter. A command is consumed on each cycle where the request and the arbiter grant are both high. Flags on the head command control the scan. End-of-queue ends the scan. Pause suspends an edge-triggered scan until the next qualifying edge. A gate that closes while the queue is triggered ends a gated scan. A sticky overrun flag records edges that arrive while the queue is already triggered. The trigger pin passes through a synchronizer chain before any detection.

Top module: `sscan_trig_ctrl`

## Requirements
- R1: After reset, scanStatus, xferReq and trigOverrun are low and the stored mode is disabled.
- R2: A write with cfgScanEn=1 and a non-disabled mode sets scanStatus one cycle later. While scanStatus is low, xferReq stays low and trigger-pin activity neither triggers the queue nor sets trigOverrun.
- R3: Mode codes on cfgMode are 0 disabled, 1 software trigger, 2 rising edge, 3 falling edge, 4 high-level gate and 5 low-level gate; codes 6 and 7 act as disabled. Writing a disabled code clears scanStatus and xferReq one cycle later, and scanStatus then stays low, even through further scan-enable writes, until another mode is written.
- R4: A mode write that also carries cfgScanEn=1 sets scanStatus in the same cycle in which the new mode takes effect.
- R5: A scan-enable write while scanStatus is already high leaves scanStatus, xferReq and trigOverrun unchanged.
- R6: In software-trigger mode, xferReq rises one cycle after scanStatus rises. A consumed command with cmdEoq=1 clears scanStatus and xferReq one cycle later.
- R7: A consumed command with cmdPause=1 and cmdEoq=0 has no effect in software-trigger or gated modes.
- R8: In edge modes, a qualifying edge on trigIn while scanStatus is high raises xferReq on the third rising clock edge after the pin changes. The opposite edge has no effect.
- R9: In edge modes, a consumed command with cmdPause=1 and cmdEoq=0 drops xferReq and keeps scanStatus high. A further qualifying edge raises xferReq again.
- R10: A qualifying edge while xferReq is high sets trigOverrun, which holds until ovrClr is pulsed. A set in the same cycle as a clear wins.
- R11: In gated modes, an open gate with scanStatus high raises xferReq one cycle after both conditions hold. If the gate is already open when scanStatus is set, xferReq rises the cycle after.
- R12: In gated modes, a gate that closes while xferReq is high clears scanStatus and xferReq, on the third rising clock edge after the pin changes.
- R13: A command is consumed only when xferReq and grant are both high. cmdEoq or cmdPause with grant low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgMode | input | 3 | Mode code written with cfgWrEn |
| cfgScanEn | input | 1 | Write-one scan-enable, valid with cfgWrEn |
| ovrClr | input | 1 | Write-one clear of trigOverrun |
| trigIn | input | 1 | Asynchronous external trigger pin |
| grant | input | 1 | Arbiter grant for this queue |
| cmdEoq | input | 1 | End-of-queue flag of the head command |
| cmdPause | input | 1 | Pause flag of the head command |
| xferReq | output | 1 | Transfer request / enable to the arbiter |
| scanStatus | output | 1 | Single-scan status bit |
| trigOverrun | output | 1 | Sticky trigger overrun flag |

## Verification
The bench sweeps all eight mode codes from reset with a combined mode and scan-enable write. The set of codes that raise scanStatus and xferReq separates the disabled encodings, the software trigger and the gate polarity taken from the idle pin level. Edge scenarios apply both edge polarities, with scanStatus low and high. This separates ignored events, true triggers, wrong-polarity edges and overruns. Pause and end-of-queue flags are offered with grant low and high in each mode family. This shows that a pause suspends only an edge scan and that only a granted command counts. Gated runs open the gate before and after the scan-enable write and then close it. This separates an immediate trigger from a waited trigger and shows that a closed gate ends the scan.

// File: rtl/sscan_trig_pkg.sv
`timescale 1ns/1ps
package sscan_trig_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF   = 3'd0,
    MD_SOFT  = 3'd1,
    MD_RISE  = 3'd2,
    MD_FALL  = 3'd3,
    MD_HIGH  = 3'd4,
    MD_LOW   = 3'd5
  } trigMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ovrSet;
  } ctlStrobe_t;

  function automatic trigMode_e decodeMode(input logic [MODE_W-1:0] code);
    case (code)
      3'd1:    decodeMode = MD_SOFT;
      3'd2:    decodeMode = MD_RISE;
      3'd3:    decodeMode = MD_FALL;
      3'd4:    decodeMode = MD_HIGH;
      3'd5:    decodeMode = MD_LOW;
      default: decodeMode = MD_OFF;
    endcase
  endfunction
endpackage

// File: rtl/sscan_trig_dp.sv
`timescale 1ns/1ps
module sscan_trig_dp
  import sscan_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trigIn,
  input  logic       ovrClr,
  input  trigMode_e  modeQ,
  input  ctlStrobe_t strb,
  output logic       edgeHit,
  output logic       gateOpen,
  output logic       trigOverrun
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] syncQ;
  logic             pinNow;
  logic             pinPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ[0] <= 1'b0;
    else        syncQ[0] <= trigIn;
  end

  genvar gi;
  generate
    for (gi = 1; gi < CHAIN; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[gi] <= 1'b0;
        else        syncQ[gi] <= syncQ[gi-1];
      end
    end
  endgenerate

  assign pinNow  = syncQ[SYNC_STAGES-1];
  assign pinPrev = syncQ[SYNC_STAGES];

  always_comb begin
    edgeHit  = 1'b0;
    gateOpen = 1'b0;
    case (modeQ)
      MD_RISE: edgeHit  = pinNow & ~pinPrev;
      MD_FALL: edgeHit  = ~pinNow & pinPrev;
      MD_HIGH: gateOpen = pinNow;
      MD_LOW:  gateOpen = ~pinNow;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           trigOverrun <= 1'b0;
    else if (strb.ovrSet) trigOverrun <= 1'b1;
    else if (ovrClr)      trigOverrun <= 1'b0;
  end

  p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ovrSet |=> trigOverrun);
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trigOverrun && !ovrClr) |=> trigOverrun);
endmodule

// File: rtl/sscan_trig_ctl.sv
`timescale 1ns/1ps
module sscan_trig_ctl
  import sscan_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgScanEn,
  input  logic              grant,
  input  logic              cmdEoq,
  input  logic              cmdPause,
  input  logic              edgeHit,
  input  logic              gateOpen,
  output trigMode_e         modeQ,
  output logic              scanStatus,
  output logic              xferReq,
  output ctlStrobe_t        strb
);
  trigMode_e modeNext;
  logic      scanQ, scanN;
  logic      trigdQ, trigdN;
  logic      consume;
  logic      isEdge, isGate;

  assign modeNext = cfgWrEn ? decodeMode(cfgMode) : modeQ;
  assign consume  = trigdQ & grant;
  assign isEdge   = (modeQ == MD_RISE) || (modeQ == MD_FALL);
  assign isGate   = (modeQ == MD_HIGH) || (modeQ == MD_LOW);

  always_comb begin
    scanN  = scanQ;
    trigdN = trigdQ;
    if (modeNext == MD_OFF) begin
      scanN  = 1'b0;
      trigdN = 1'b0;
    end else begin
      if (consume && cmdEoq) begin
        scanN  = 1'b0;
        trigdN = 1'b0;
      end else if (modeQ == MD_SOFT) begin
        if (scanQ) trigdN = 1'b1;
      end else if (isEdge) begin
        if (consume && cmdPause)    trigdN = 1'b0;
        else if (scanQ && edgeHit)  trigdN = 1'b1;
      end else if (isGate) begin
        if (trigdQ && !gateOpen) begin
          scanN  = 1'b0;
          trigdN = 1'b0;
        end else if (scanQ && gateOpen) begin
          trigdN = 1'b1;
        end
      end
      if (cfgWrEn && cfgScanEn && !scanQ) scanN = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ  <= MD_OFF;
      scanQ  <= 1'b0;
      trigdQ <= 1'b0;
    end else begin
      modeQ  <= modeNext;
      scanQ  <= scanN;
      trigdQ <= trigdN;
    end
  end

  assign scanStatus  = scanQ;
  assign xferReq     = trigdQ;
  assign strb.ovrSet = trigdQ & edgeHit;

  p_xfer_needs_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xferReq |-> scanStatus);
  p_off_holds_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MD_OFF) |-> !scanStatus);
  p_eoq_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xferReq && grant && cmdEoq) |=> !xferReq);
  p_soft_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MD_SOFT && xferReq && grant && cmdPause && !cmdEoq && !cfgWrEn)
      |=> xferReq);
  p_edge_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (isEdge && xferReq && grant && cmdPause && !cmdEoq && !cfgWrEn)
      |=> (scanStatus && !xferReq));
  p_gate_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (isGate && xferReq && !gateOpen && !cfgWrEn) |=> !scanStatus);
endmodule

// File: rtl/sscan_trig_ctrl.sv
`timescale 1ns/1ps
module sscan_trig_ctrl
  import sscan_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [2:0] cfgMode,
  input  logic       cfgScanEn,
  input  logic       ovrClr,
  input  logic       trigIn,
  input  logic       grant,
  input  logic       cmdEoq,
  input  logic       cmdPause,
  output logic       xferReq,
  output logic       scanStatus,
  output logic       trigOverrun
);
  trigMode_e  modeQ;
  ctlStrobe_t strb;
  logic       edgeHit;
  logic       gateOpen;

  sscan_trig_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgMode    (cfgMode),
    .cfgScanEn  (cfgScanEn),
    .grant      (grant),
    .cmdEoq     (cmdEoq),
    .cmdPause   (cmdPause),
    .edgeHit    (edgeHit),
    .gateOpen   (gateOpen),
    .modeQ      (modeQ),
    .scanStatus (scanStatus),
    .xferReq    (xferReq),
    .strb       (strb)
  );

  sscan_trig_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigIn      (trigIn),
    .ovrClr      (ovrClr),
    .modeQ       (modeQ),
    .strb        (strb),
    .edgeHit     (edgeHit),
    .gateOpen    (gateOpen),
    .trigOverrun (trigOverrun)
  );
endmodule

// File: tb/sscan_trig_ctrl_tb.sv
`timescale 1ns/1ps
module sscan_trig_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgMode = 3'd0;
  logic       cfgScanEn = 1'b0;
  logic       ovrClr = 1'b0;
  logic       trigIn = 1'b0;
  logic       grant = 1'b0;
  logic       cmdEoq = 1'b0;
  logic       cmdPause = 1'b0;
  logic       xferReq, scanStatus, trigOverrun;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sscan_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .cfgScanEn(cfgScanEn), .ovrClr(ovrClr), .trigIn(trigIn), .grant(grant),
    .cmdEoq(cmdEoq), .cmdPause(cmdPause), .xferReq(xferReq),
    .scanStatus(scanStatus), .trigOverrun(trigOverrun)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; trigIn = 1'b0; grant = 1'b0; cmdEoq = 1'b0; cmdPause = 1'b0;
    cfgWrEn = 1'b0; cfgScanEn = 1'b0; ovrClr = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wr(input int m, input bit se);
    cfgWrEn = 1'b1; cfgMode = 3'(m); cfgScanEn = se;
    step(1);
    cfgWrEn = 1'b0; cfgScanEn = 1'b0;
  endtask

  task automatic consume(input bit eoq, input bit pau, input bit g);
    grant = g; cmdEoq = eoq; cmdPause = pau;
    step(1);
    grant = 1'b0; cmdEoq = 1'b0; cmdPause = 1'b0;
  endtask

  // pin change then three clock edges: qualifying transition has acted
  task automatic pin(input bit v);
    trigIn = v;
    step(3);
  endtask

  initial begin
    doReset();
    chk("R1", "scanStatus", scanStatus, 0);
    chk("R1", "xferReq", xferReq, 0);
    chk("R1", "trigOverrun", trigOverrun, 0);

    // sweep all codes with combined mode + scan-enable write (R3, R4)
    for (int m = 0; m < 8; m++) begin
      doReset();
      wr(m, 1'b1);
      chk("R4", $sformatf("scan after write code %0d", m), scanStatus, (m >= 1 && m <= 5) ? 1 : 0);
      step(1);
      // idle pin low: software triggers, low gate is open
      chk("R3", $sformatf("xfer code %0d", m), xferReq, (m == 1 || m == 5) ? 1 : 0);
      chk("R2", $sformatf("ovr code %0d", m), trigOverrun, 0);
    end

    // R2: triggers ignored while scan low
    doReset();
    wr(2, 1'b0);
    pin(1'b1); pin(1'b0); pin(1'b1);
    chk("R2", "xfer rising no scan", xferReq, 0);
    chk("R2", "ovr rising no scan", trigOverrun, 0);
    wr(4, 1'b0);
    step(2);
    chk("R2", "xfer gate open no scan", xferReq, 0);

    // R6, R13, R5, R7 in software mode
    doReset();
    wr(1, 1'b1);
    chk("R6", "xfer same cycle as scan", xferReq, 0);
    step(1);
    chk("R6", "xfer one after scan", xferReq, 1);
    consume(1'b1, 1'b0, 1'b0);
    chk("R13", "eoq without grant keeps scan", scanStatus, 1);
    chk("R13", "eoq without grant keeps xfer", xferReq, 1);
    wr(1, 1'b1);
    chk("R5", "rewrite keeps scan", scanStatus, 1);
    chk("R5", "rewrite no ovr", trigOverrun, 0);
    chk("R5", "rewrite keeps xfer", xferReq, 1);
    consume(1'b0, 1'b1, 1'b1);
    chk("R7", "soft pause ignored", xferReq, 1);
    consume(1'b1, 1'b0, 1'b1);
    chk("R6", "eoq clears scan", scanStatus, 0);
    chk("R6", "eoq clears xfer", xferReq, 0);
    step(3);
    chk("R6", "stays idle after eoq", xferReq, 0);

    // R3: disable clears; scan-enable ignored while disabled
    wr(1, 1'b1);
    step(1);
    wr(0, 1'b0);
    chk("R3", "disable clears scan", scanStatus, 0);
    chk("R3", "disable clears xfer", xferReq, 0);
    wr(0, 1'b1);
    chk("R3", "scan-en while off", scanStatus, 0);
    wr(7, 1'b1);
    chk("R3", "code 7 acts off", scanStatus, 0);

    // R8, R9, R10 rising edge mode
    doReset();
    wr(2, 1'b1);
    trigIn = 1'b1;
    step(2);
    chk("R8", "xfer before third edge", xferReq, 0);
    step(1);
    chk("R8", "xfer on third edge", xferReq, 1);
    pin(1'b0);
    chk("R10", "falling edge no ovr in rising mode", trigOverrun, 0);
    pin(1'b1);
    chk("R10", "overrun set", trigOverrun, 1);
    step(2);
    chk("R10", "overrun sticky", trigOverrun, 1);
    ovrClr = 1'b1; step(1); ovrClr = 1'b0;
    chk("R10", "overrun cleared", trigOverrun, 0);
    consume(1'b0, 1'b1, 1'b0);
    chk("R13", "pause without grant", xferReq, 1);
    consume(1'b0, 1'b1, 1'b1);
    chk("R9", "pause drops xfer", xferReq, 0);
    chk("R9", "pause keeps scan", scanStatus, 1);
    pin(1'b0);
    chk("R9", "opposite edge no resume", xferReq, 0);
    pin(1'b1);
    chk("R9", "edge resumes", xferReq, 1);
    chk("R9", "resume not overrun", trigOverrun, 0);
    consume(1'b1, 1'b0, 1'b1);
    chk("R6", "eoq ends edge scan", scanStatus, 0);
    pin(1'b0); pin(1'b1);
    chk("R2", "edge after eoq ignored", xferReq, 0);

    // R8 falling edge mode; set and clear in same cycle (R10)
    doReset();
    trigIn = 1'b1; step(3);
    wr(3, 1'b1);
    pin(1'b1);
    chk("R8", "no edge no xfer", xferReq, 0);
    pin(1'b0);
    chk("R8", "falling triggers", xferReq, 1);
    trigIn = 1'b1; step(3);
    trigIn = 1'b0; step(2);
    ovrClr = 1'b1; step(1); ovrClr = 1'b0;
    chk("R10", "set wins over clear", trigOverrun, 1);

    // R11, R12 high gate: open after scan set
    doReset();
    wr(4, 1'b1);
    step(2);
    chk("R11", "closed gate waits", xferReq, 0);
    trigIn = 1'b1;
    step(2);
    chk("R11", "gate not yet seen", xferReq, 0);
    step(1);
    chk("R11", "gate open triggers", xferReq, 1);
    consume(1'b0, 1'b1, 1'b1);
    chk("R7", "gate pause ignored", xferReq, 1);
    trigIn = 1'b0;
    step(2);
    chk("R12", "scan before close acts", scanStatus, 1);
    step(1);
    chk("R12", "close clears scan", scanStatus, 0);
    chk("R12", "close clears xfer", xferReq, 0);
    pin(1'b1);
    chk("R12", "reopen after end ignored", xferReq, 0);

    // R11 gate already open when scan set, then eoq
    wr(4, 1'b1);
    chk("R11", "scan set", scanStatus, 1);
    step(1);
    chk("R11", "immediate trigger", xferReq, 1);
    consume(1'b1, 1'b0, 1'b1);
    chk("R12", "eoq ends gated scan", scanStatus, 0);
    step(2);
    chk("R12", "no retrigger after eoq", xferReq, 0);

    // low gate: high pin keeps it closed
    doReset();
    trigIn = 1'b1; step(3);
    wr(5, 1'b1);
    step(2);
    chk("R11", "low gate closed", xferReq, 0);
    trigIn = 1'b0; step(3);
    chk("R11", "low gate opens", xferReq, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule